// File: doc/BRIEF.md
# Configuration Image Integrity Checker

This block decides whether a stored configuration image may be booted. The caller first pulses `start_i` with the image's header fields applied (a 16-bit status code, a 16-bit stored CRC and a 24-bit byte length). It then streams the image bytes, one byte per cycle whenever `in_valid_i` is high. The checker looks at three things: the header status, the synchronisation preamble at the head of the image, and a retry-on-error option triple that must sit early in the image. It can also run a byte-serial CRC-16 over exactly the header's byte count and compare the result with the stored value.

The checker reports its verdict as soon as it knows it. That is either on the first byte that breaks a rule or on the final counted byte. It raises `done_o` for one cycle and drives `pass_o` and a reason code, which hold until the next verdict. Fetching the image from storage and acting on the verdict are left to the surrounding logic.

Top module: `imgchk_top`

## Requirements
- R1: After reset, `done_o`, `pass_o` and `reason_o` are all 0.
- R2: If the status code latched at `start_i` is anything other than 0x00FF (for example the empty code 0xFFFF or the revoked code 0x0000), `done_o` rises in the next cycle with `pass_o`=0 and reason 1 (status), and the byte stream is not examined.
- R3: Counting from byte index 0, the image must open with one or more 0xFF bytes, followed at once by 0xAA and then 0x99. The first byte that breaks this rule ends the check with reason 2 (sync).
- R4: The byte triple 0x31, 0x61, X with X bit 7 set must appear with X at a byte index of 63 or below. If byte 63 is accepted without such a match, the check ends with reason 3 (option). A match whose X lands at index 64 or later does not count.
- R5: The image is exactly `hdr_len_i` bytes long, and the verdict is due on byte index `hdr_len_i`-1. At that byte, an unfinished preamble gives reason 2 and a missing option triple gives reason 3. A length of 0 gives reason 2 in the cycle after `start_i`.
- R6: The CRC is computed over all counted bytes. It uses polynomial 0x8005 (x^16+x^15+x^2+1), starts at 0x0000, takes each byte MSB first, is not reflected and has no final XOR. A mismatch with the stored value gives reason 4 (crc). When every rule holds, the verdict is `pass_o`=1 with reason 0.
- R7: With parameter CHECK_CRC=0 the CRC is not computed, and an image that breaks no other rule passes whatever stored CRC it carries.
- R8: `done_o` is high for exactly one cycle, namely the cycle after the deciding byte (or after `start_i` for R2 and zero length). `pass_o` and `reason_o` change only together with `done_o`.
- R9: The checker ignores bytes presented while `in_valid_i` is low, before any `start_i`, or after a verdict. Such bytes change no output and do not affect the next image.
- R10: A `start_i` during an image abandons that image without a verdict and begins a fresh check with the newly applied header.
- R11: When several rules fail on the same byte, the reason follows the order sync, then option, then crc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Latches the header and begins a new image check |
| hdr_status_i | input | 16 | Header status code, sampled on `start_i` |
| hdr_crc_i | input | 16 | Stored CRC-16 of the image, sampled on `start_i` |
| hdr_len_i | input | 24 | Image length in bytes, sampled on `start_i` |
| in_valid_i | input | 1 | Qualifies `in_byte_i` for this cycle |
| in_byte_i | input | 8 | Image byte |
| done_o | output | 1 | One-cycle verdict strobe |
| pass_o | output | 1 | 1 when the last verdict allows booting |
| reason_o | output | 3 | Fail reason: 0 none, 1 status, 2 sync, 3 option, 4 crc |

## Verification
The assertions watch every cycle for the following: the single-cycle shape of the verdict strobe, outputs that stay fixed between verdicts, reason codes within range and consistent with the pass flag, and the one-cycle rejection after `start_i` for a bad status or zero length. Other behaviour depends on the byte history, and only the bench's scenarios can show it. This covers where a preamble break or a late option triple is caught, CRC agreement over the exact length, the priority between reasons, restarts in mid-image and the bypass variant without the CRC. A behavioural model in the bench tracks those scenarios cycle by cycle.

// File: rtl/imgchk_pkg.sv
package imgchk_pkg;

    typedef enum logic [2:0] {
        RSN_NONE   = 3'd0,
        RSN_STATUS = 3'd1,
        RSN_SYNC   = 3'd2,
        RSN_OPTION = 3'd3,
        RSN_CRC    = 3'd4
    } reason_e;

    localparam logic [15:0] STATUS_BOOTABLE = 16'h00FF;
    localparam logic [7:0]  PRE_FILL        = 8'hFF;
    localparam logic [7:0]  PRE_MARK0       = 8'hAA;
    localparam logic [7:0]  PRE_MARK1       = 8'h99;
    localparam logic [7:0]  OPT_TAG0        = 8'h31;
    localparam logic [7:0]  OPT_TAG1        = 8'h61;

    typedef enum logic [1:0] {
        PRE_WAIT_FIRST,
        PRE_IN_FILL,
        PRE_WAIT_MARK1,
        PRE_LOCKED
    } pre_state_e;

    typedef enum logic {
        CHK_IDLE,
        CHK_RUN
    } chk_state_e;

    // One byte through a non-reflected CRC-16, bits taken MSB first.
    function automatic logic [15:0] crc16_step(input logic [15:0] cur,
                                               input logic [7:0]  data,
                                               input logic [15:0] poly);
        logic [15:0] r;
        r = cur;
        for (int i = 7; i >= 0; i--) begin
            if (r[15] ^ data[i]) r = (r << 1) ^ poly;
            else                 r = r << 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/imgchk_crc16.sv
module imgchk_crc16 #(
    parameter logic [15:0] POLY = 16'h8005,
    parameter logic [15:0] SEED = 16'h0000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       step_i,
    input  logic [7:0] byte_i,
    output logic [7:0] with_lo_o,
    output logic [7:0] with_hi_o
);
    import imgchk_pkg::*;

    typedef struct packed {
        logic [15:0] acc;
    } crc_st_t;

    crc_st_t st_d, st_q;
    logic [15:0] with_byte;

    always_comb begin
        with_byte = crc16_step(st_q.acc, byte_i, POLY);
        st_d      = st_q;
        if (clear_i)     st_d.acc = SEED;
        else if (step_i) st_d.acc = with_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{acc: SEED};
        else        st_q <= st_d;
    end

    // Result including the byte on the input, split into bytes.
    assign with_lo_o = with_byte[7:0];
    assign with_hi_o = with_byte[15:8];

endmodule

// File: rtl/imgchk_preamble.sv
module imgchk_preamble (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       step_i,
    input  logic [7:0] byte_i,
    output logic       ok_now_o,
    output logic       bad_now_o
);
    import imgchk_pkg::*;

    typedef struct packed {
        pre_state_e st;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        ok_now_o  = 1'b0;
        bad_now_o = 1'b0;
        unique case (st_q.st)
            PRE_WAIT_FIRST: begin
                bad_now_o = (byte_i != PRE_FILL);
                if (step_i && !bad_now_o) st_d.st = PRE_IN_FILL;
            end
            PRE_IN_FILL: begin
                bad_now_o = (byte_i != PRE_FILL) && (byte_i != PRE_MARK0);
                if (step_i && byte_i == PRE_MARK0) st_d.st = PRE_WAIT_MARK1;
            end
            PRE_WAIT_MARK1: begin
                bad_now_o = (byte_i != PRE_MARK1);
                ok_now_o  = !bad_now_o;
                if (step_i && ok_now_o) st_d.st = PRE_LOCKED;
            end
            PRE_LOCKED: begin
                ok_now_o = 1'b1;
            end
            default: st_d.st = PRE_WAIT_FIRST;
        endcase
        if (clear_i) st_d.st = PRE_WAIT_FIRST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{st: PRE_WAIT_FIRST};
        else        st_q <= st_d;
    end

endmodule

// File: rtl/imgchk_optscan.sv
module imgchk_optscan #(
    parameter int WIN = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       step_i,
    input  logic [7:0] byte_i,
    output logic       found_now_o,
    output logic       miss_now_o
);
    import imgchk_pkg::*;

    localparam int IDX_W = $clog2(WIN + 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WIN - 1);
    localparam logic [IDX_W-1:0] IDX_END  = IDX_W'(WIN);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [7:0]       prev1;
        logic [7:0]       prev2;
        logic             found;
    } opt_st_t;

    opt_st_t st_d, st_q;
    logic    in_win;
    logic    hit;

    always_comb begin
        in_win      = (st_q.idx < IDX_END);
        hit         = in_win && (st_q.prev2 == OPT_TAG0) &&
                      (st_q.prev1 == OPT_TAG1) && byte_i[7];
        found_now_o = st_q.found || hit;
        miss_now_o  = (st_q.idx == IDX_LAST) && !found_now_o;

        st_d = st_q;
        if (clear_i) begin
            st_d = '0;
        end else if (step_i) begin
            if (in_win) st_d.idx = st_q.idx + IDX_W'(1);
            st_d.prev2 = st_q.prev1;
            st_d.prev1 = byte_i;
            st_d.found = found_now_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/imgchk_top.sv
module imgchk_top #(
    parameter int          LEN_W     = 24,
    parameter int          OPT_WIN   = 64,
    parameter bit          CHECK_CRC = 1'b1,
    parameter logic [15:0] CRC_POLY  = 16'h8005,
    parameter logic [15:0] CRC_SEED  = 16'h0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [15:0]      hdr_status_i,
    input  logic [15:0]      hdr_crc_i,
    input  logic [LEN_W-1:0] hdr_len_i,
    input  logic             in_valid_i,
    input  logic [7:0]       in_byte_i,
    output logic             done_o,
    output logic             pass_o,
    output logic [2:0]       reason_o
);
    import imgchk_pkg::*;

    typedef struct packed {
        chk_state_e       state;
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] len;
        logic [15:0]      crc_exp;
        logic             done;
        logic             pass;
        reason_e          reason;
    } top_st_t;

    top_st_t st_d, st_q;

    logic step;
    logic pre_ok, pre_bad;
    logic opt_found, opt_miss;
    logic crc_ok;
    logic last_byte;

    assign step = (st_q.state == CHK_RUN) && in_valid_i && !start_i;

    imgchk_preamble u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (start_i),
        .step_i    (step),
        .byte_i    (in_byte_i),
        .ok_now_o  (pre_ok),
        .bad_now_o (pre_bad)
    );

    imgchk_optscan #(.WIN(OPT_WIN)) u_opt (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (start_i),
        .step_i      (step),
        .byte_i      (in_byte_i),
        .found_now_o (opt_found),
        .miss_now_o  (opt_miss)
    );

    generate
        if (CHECK_CRC) begin : g_crc
            logic [7:0] lo, hi;
            imgchk_crc16 #(.POLY(CRC_POLY), .SEED(CRC_SEED)) u_crc (
                .clk       (clk),
                .rst_n     (rst_n),
                .clear_i   (start_i),
                .step_i    (step),
                .byte_i    (in_byte_i),
                .with_lo_o (lo),
                .with_hi_o (hi)
            );
            assign crc_ok = ({hi, lo} == st_q.crc_exp);
        end else begin : g_nocrc
            assign crc_ok = 1'b1;
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        last_byte = (st_q.cnt == st_q.len - LEN_W'(1));

        if (start_i) begin
            st_d.len     = hdr_len_i;
            st_d.crc_exp = hdr_crc_i;
            st_d.cnt     = '0;
            if (hdr_status_i != STATUS_BOOTABLE) begin
                st_d.state  = CHK_IDLE;
                st_d.done   = 1'b1;
                st_d.pass   = 1'b0;
                st_d.reason = RSN_STATUS;
            end else if (hdr_len_i == '0) begin
                st_d.state  = CHK_IDLE;
                st_d.done   = 1'b1;
                st_d.pass   = 1'b0;
                st_d.reason = RSN_SYNC;
            end else begin
                st_d.state = CHK_RUN;
            end
        end else if (step) begin
            st_d.cnt = st_q.cnt + LEN_W'(1);
            if (pre_bad || opt_miss || last_byte) begin
                st_d.state = CHK_IDLE;
                st_d.done  = 1'b1;
                st_d.pass  = 1'b0;
                if (pre_bad || (last_byte && !pre_ok)) st_d.reason = RSN_SYNC;
                else if (opt_miss || !opt_found)       st_d.reason = RSN_OPTION;
                else if (!crc_ok)                      st_d.reason = RSN_CRC;
                else begin
                    st_d.pass   = 1'b1;
                    st_d.reason = RSN_NONE;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: CHK_IDLE, cnt: '0, len: '0, crc_exp: '0,
                      done: 1'b0, pass: 1'b0, reason: RSN_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o   = st_q.done;
    assign pass_o   = st_q.pass;
    assign reason_o = st_q.reason;

endmodule

// File: rtl/imgchk_chk.sv
module imgchk_chk #(
    parameter int LEN_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [15:0]      hdr_status_i,
    input logic [LEN_W-1:0] hdr_len_i,
    input logic             done_o,
    input logic             pass_o,
    input logic [2:0]       reason_o
);
    import imgchk_pkg::*;

    // R2: a non-bootable status is rejected in the following cycle
    assert_status_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && hdr_status_i != STATUS_BOOTABLE |=> done_o && !pass_o && reason_o == 3'd1);

    // R5: zero length fails as sync in the following cycle
    assert_zero_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && hdr_status_i == STATUS_BOOTABLE && hdr_len_i == '0
        |=> done_o && reason_o == 3'd2);

    // R8: verdict strobe lasts a single cycle unless a new start arrives
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !start_i |=> !done_o);

    // R8: verdict outputs hold between strobes
    assert_verdict_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(pass_o) && $stable(reason_o));

    // R6: a pass carries no reason, a fail carries a defined one
    assert_reason_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (pass_o ? reason_o == 3'd0 : (reason_o >= 3'd1 && reason_o <= 3'd4)));

endmodule

bind imgchk_top imgchk_chk #(.LEN_W(LEN_W)) u_imgchk_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .hdr_status_i (hdr_status_i),
    .hdr_len_i    (hdr_len_i),
    .done_o       (done_o),
    .pass_o       (pass_o),
    .reason_o     (reason_o)
);

// File: tb/tb_imgchk_top.sv
module tb_imgchk_top;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n;
    logic        start;
    logic [15:0] hstat, hcrc;
    logic [23:0] hlen;
    logic        in_valid;
    logic [7:0]  in_byte;
    logic        done, pass;
    logic [2:0]  reason;
    logic        nc_done, nc_pass;
    logic [2:0]  nc_reason;

    imgchk_top dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .hdr_status_i(hstat),
        .hdr_crc_i(hcrc), .hdr_len_i(hlen), .in_valid_i(in_valid),
        .in_byte_i(in_byte), .done_o(done), .pass_o(pass), .reason_o(reason)
    );

    imgchk_top #(.CHECK_CRC(1'b0)) dut_nc (
        .clk(clk), .rst_n(rst_n), .start_i(start), .hdr_status_i(hstat),
        .hdr_crc_i(hcrc), .hdr_len_i(hlen), .in_valid_i(in_valid),
        .in_byte_i(in_byte), .done_o(nc_done), .pass_o(nc_pass), .reason_o(nc_reason)
    );

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    string cur_req = "R1";
    bit    seen_done = 1'b0;
    bit    model_on = 1'b0;
    logic [7:0] img[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference ----------------
    logic [7:0]  m_q[$];
    bit          m_run;
    int          m_len;
    logic [15:0] m_crc_exp;
    logic        m_done, m_pass;
    logic [2:0]  m_reason;

    function automatic int ref_sync(input logic [7:0] q[$]);
        int i;
        if (q.size() == 0) return 0;
        if (q[0] != 8'hFF) return 2;
        i = 1;
        while (i < q.size() && q[i] == 8'hFF) i++;
        if (i == q.size()) return 0;
        if (q[i] != 8'hAA) return 2;
        if (i + 1 == q.size()) return 0;
        if (q[i+1] != 8'h99) return 2;
        return 1;
    endfunction

    function automatic bit ref_opt(input logic [7:0] q[$]);
        for (int j = 2; j < q.size() && j < 64; j++)
            if (q[j-2] == 8'h31 && q[j-1] == 8'h61 && q[j][7]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [15:0] ref_crc(input logic [7:0] q[$], input int n);
        logic [15:0] r = 16'h0000;
        for (int k = 0; k < n; k++) begin
            r ^= {q[k], 8'h00};
            for (int b = 0; b < 8; b++) r = r[15] ? ((r << 1) ^ 16'h8005) : (r << 1);
        end
        return r;
    endfunction

    task automatic m_verdict(input bit p, input int r);
        m_run    = 1'b0;
        m_done   = 1'b1;
        m_pass   = p;
        m_reason = 3'(r);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_done = 0; m_pass = 0; m_reason = 0; m_q.delete();
        end else begin
            m_done = 1'b0;
            if (start) begin
                m_q.delete();
                m_len = int'(hlen);
                m_crc_exp = hcrc;
                if (hstat != 16'h00FF) m_verdict(0, 1);
                else if (hlen == 0)    m_verdict(0, 2);
                else                   m_run = 1'b1;
            end else if (m_run && in_valid) begin
                int s;
                m_q.push_back(in_byte);
                s = ref_sync(m_q);
                if (s == 2) m_verdict(0, 2);
                else if (!ref_opt(m_q) && m_q.size() == 64) m_verdict(0, 3);
                else if (m_q.size() == m_len) begin
                    if (s != 1)                                m_verdict(0, 2);
                    else if (!ref_opt(m_q))                    m_verdict(0, 3);
                    else if (ref_crc(m_q, m_len) != m_crc_exp) m_verdict(0, 4);
                    else                                       m_verdict(1, 0);
                end
            end
        end
    end

    // per-cycle comparison, watchdog
    always @(negedge clk) begin
        cycles++;
        if (done) seen_done = 1'b1;
        if (model_on) begin
            chk(done == m_done, cur_req, "model done", done, m_done);
            chk(pass == m_pass, cur_req, "model pass", pass, m_pass);
            chk(reason == m_reason, cur_req, "model reason", reason, m_reason);
        end
        if (cycles > 100000) begin
            chk(1'b0, cur_req, "watchdog expired", cycles, 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic mk_good(input int n);
        img.delete();
        img = '{8'hFF, 8'hFF, 8'hFF, 8'hAA, 8'h99, 8'h31, 8'h61, 8'h80};
        while (img.size() < n) img.push_back(8'h20 + 8'(img.size() % 16));
    endtask

    task automatic mk_fill(input int n);
        img.delete();
        img = '{8'hFF, 8'hAA, 8'h99};
        while (img.size() < n) img.push_back(8'h20 + 8'(img.size() % 16));
    endtask

    task automatic send_start(input logic [15:0] st, input int len, input logic [15:0] crc);
        @(negedge clk);
        seen_done = 1'b0;
        start = 1'b1; hstat = st; hlen = 24'(len); hcrc = crc;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send_bytes(input int from, input int upto, input int gap);
        for (int i = from; i < upto && i < img.size(); i++) begin
            in_valid = 1'b1; in_byte = img[i];
            @(negedge clk);
            in_valid = 1'b0;
            if (gap > 0 && (i % gap) == gap - 1) begin
                in_byte = 8'h31;
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
    endtask

    task automatic expect_verdict(input bit ep, input int er, input string req);
        repeat (3) @(negedge clk);
        chk(seen_done, req, "done seen", seen_done, 1);
        chk(pass == ep, req, "pass", pass, ep);
        chk(reason == 3'(er), req, "reason", reason, er);
    endtask

    task automatic run_image(input logic [15:0] st, input int len, input logic [15:0] crc,
                             input int gap, input bit ep, input int er, input string req);
        cur_req = req;
        send_start(st, len, crc);
        send_bytes(0, img.size(), gap);
        expect_verdict(ep, er, req);
    endtask

    initial begin
        rst_n = 0; start = 0; hstat = 0; hcrc = 0; hlen = 0; in_valid = 0; in_byte = 0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(done == 0 && pass == 0 && reason == 0, "R1", "reset outputs",
            {29'd0, done, pass, reason[0]}, 0);
        rst_n = 1;
        @(negedge clk);
        model_on = 1'b1;

        // R9: bytes before any start are ignored
        cur_req = "R9";
        mk_good(20);
        send_bytes(0, 20, 0);
        repeat (2) @(negedge clk);
        chk(!seen_done && pass == 0 && reason == 0, "R9", "idle bytes no verdict", seen_done, 0);

        // R2: empty and revoked status codes
        mk_good(20);
        run_image(16'hFFFF, 20, ref_crc(img, 20), 0, 0, 1, "R2");
        run_image(16'h0000, 20, ref_crc(img, 20), 0, 0, 1, "R2");

        // R6: well-formed image passes
        mk_good(40);
        run_image(16'h00FF, 40, ref_crc(img, 40), 0, 1, 0, "R6");

        // R3: first byte not fill
        mk_good(30); img[0] = 8'h00;
        run_image(16'h00FF, 30, 16'h0, 0, 0, 2, "R3");
        // R3: wrong byte after 0xAA
        mk_good(30); img[3] = 8'hAA; img[4] = 8'h55;
        run_image(16'h00FF, 30, 16'h0, 0, 0, 2, "R3");
        // R3: bare marker without fill
        mk_good(30); img[0] = 8'hAA;
        run_image(16'h00FF, 30, 16'h0, 0, 0, 2, "R3");

        // R4: no option in window, longer image; R9 later bytes ignored
        mk_fill(100);
        run_image(16'h00FF, 100, ref_crc(img, 100), 0, 0, 3, "R4");
        // R4: option whose X lands at index 63 passes
        mk_fill(80); img[61] = 8'h31; img[62] = 8'h61; img[63] = 8'hC5;
        run_image(16'h00FF, 80, ref_crc(img, 80), 0, 1, 0, "R4");
        // R4: X at index 64 is too late
        mk_fill(80); img[62] = 8'h31; img[63] = 8'h61; img[64] = 8'hC5;
        run_image(16'h00FF, 80, ref_crc(img, 80), 0, 0, 3, "R4");
        // R4: X with bit 7 clear
        mk_good(30); img[7] = 8'h7F;
        run_image(16'h00FF, 30, ref_crc(img, 30), 0, 0, 3, "R4");

        // R6: CRC mismatch; R7: bypass variant still passes
        mk_good(50);
        run_image(16'h00FF, 50, ref_crc(img, 50) ^ 16'h0100, 0, 0, 4, "R6");
        chk(nc_pass == 1 && nc_reason == 0, "R7", "bypass pass", {nc_pass, nc_reason}, 8);

        // R5: length ends inside preamble, inside option, and zero length
        mk_good(40);
        run_image(16'h00FF, 3, ref_crc(img, 3), 0, 0, 2, "R5");
        run_image(16'h00FF, 7, ref_crc(img, 7), 0, 0, 3, "R5");
        run_image(16'h00FF, 0, 16'h0, 0, 0, 2, "R5");
        // R5: CRC bounded by the length, extra bytes not counted
        run_image(16'h00FF, 25, ref_crc(img, 25), 0, 1, 0, "R5");

        // R8: gaps in valid do not disturb the result
        mk_good(60);
        run_image(16'h00FF, 60, ref_crc(img, 60), 3, 1, 0, "R8");

        // R10: restart mid-image
        cur_req = "R10";
        mk_fill(70);
        send_start(16'h00FF, 70, 16'h0);
        send_bytes(0, 12, 0);
        chk(!seen_done, "R10", "no verdict yet", seen_done, 0);
        mk_good(30);
        run_image(16'h00FF, 30, ref_crc(img, 30), 0, 1, 0, "R10");

        // R11: option missing and CRC wrong -> option; sync bad and CRC wrong -> sync
        mk_fill(10);
        run_image(16'h00FF, 10, ref_crc(img, 10) ^ 16'h1, 0, 0, 3, "R11");
        mk_good(10); img[4] = 8'h98;
        run_image(16'h00FF, 10, ref_crc(img, 10) ^ 16'h1, 0, 0, 2, "R11");

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule